// File: doc/BRIEF.md
# Double-Rate Input Capture and Word Widening

This block takes a data bus that carries one half-word on each edge of a capture clock and turns it into a single-rate word of twice the width. Two separate register paths do the sampling: one is clocked on the rising edge and one on the falling edge. At the next rising edge the two samples are joined into one wide word, and a valid flag goes high when both samples were flagged valid.

The capture clock comes in from outside. It must already be shifted by about a quarter period, so that its edges fall in the middle of each data eye. The wide word and its flag stay in the capture-clock domain. A dual-clock FIFO placed after the block carries them into the system clock domain. No register in the block is written from both clock edges: each storage element has exactly one clock edge.

Top module: `ddr_capture_widen`

## Requirements
- R1: The half-word sampled on a rising edge of `capClk` appears in the low half of `wideData`, bits [DW-1:0].
- R2: The half-word sampled on the falling edge that follows appears in the high half of `wideData`, bits [2*DW-1:DW].
- R3: A beat's wide word and flag change on the first rising edge after that beat's falling-edge sample, so the latency is one `capClk` cycle from the rising sample. Between edges the outputs keep their previous values.
- R4: `wideValid` is 1 for a beat only when `ddrValid` was 1 at both the rising-edge sample and the falling-edge sample of that beat. Otherwise it is 0.
- R5: When a beat is not valid, `wideData` keeps the last valid word unchanged.
- R6: An active-high `rst` clears `wideData` and `wideValid` to 0 at once, without waiting for a clock edge, and holds them cleared while it stays high.
- R7: Valid beats on consecutive cycles each produce a wide word, one per `capClk` cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| capClk | input | 1 | Capture clock, centred in the data eye |
| rst | input | 1 | Asynchronous reset, active high |
| ddrData | input | DW | Half-word bus, one value per clock edge |
| ddrValid | input | 1 | Valid qualifier, sampled on both edges with the data |
| wideData | output | 2*DW | Joined word: rising sample low, falling sample high |
| wideValid | output | 1 | Marks a word built from two valid samples |

## Verification
Random half-words and a valid qualifier that is set about three beats in four are fed every cycle. Because the low and high halves always differ, a mistake in lane order, a missed edge or an off-by-one pairing is visible. Directed beats cover these cases:
- Valid on the rising sample only, and valid on the falling sample only: these tell a correct AND of the two flags from a rule that looks at one edge.
- All-ones paired with all-zeros in both orders: these expose swapped halves.
- A reset raised halfway between edges: this separates an asynchronous clear from a synchronous one.

In every beat, a mid-cycle check confirms that the outputs have not moved before the rising edge.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

  // Strobes passed from the qualifier control to the datapath
  typedef struct packed {
    logic loadWide;   // both halves of the current beat are valid
  } capStrobes_t;

endpackage

// File: rtl/ddr_cap_ctrl.sv
module ddr_cap_ctrl
  import ddr_cap_pkg::*;
(
  input  logic        capClk,
  input  logic        rst,
  input  logic        ddrValid,
  output capStrobes_t strobes,
  output logic        wideValid
);

  logic riseVld;
  logic fallVld;
  logic beatOk;

  // qualifier sampled with the rising-edge half
  always_ff @(posedge capClk or posedge rst) begin
    if (rst) riseVld <= 1'b0;
    else     riseVld <= ddrValid;
  end

  // qualifier sampled with the falling-edge half
  always_ff @(negedge capClk or posedge rst) begin
    if (rst) fallVld <= 1'b0;
    else     fallVld <= ddrValid;
  end

  assign beatOk = riseVld & fallVld;

  always_comb begin
    strobes          = '0;
    strobes.loadWide = beatOk;
  end

  always_ff @(posedge capClk or posedge rst) begin
    if (rst) wideValid <= 1'b0;
    else     wideValid <= beatOk;
  end

  // R4: a valid word needs both edge qualifiers of its beat
  p_valid_pair_r4: assert property (@(posedge capClk) disable iff (rst)
    wideValid |-> ($past(riseVld) && $past(fallVld)));

  // R4: a beat with either qualifier low yields no valid word
  p_invalid_beat_r4: assert property (@(posedge capClk) disable iff (rst)
    !(riseVld && fallVld) |=> !wideValid);

  // R6: reset holds the flag low
  always @(negedge capClk) begin
    if (rst) p_reset_clear_r6: assert (!wideValid);
  end

endmodule

// File: rtl/ddr_cap_dpath.sv
module ddr_cap_dpath
  import ddr_cap_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          capClk,
  input  logic          rst,
  input  logic [DW-1:0] ddrData,
  input  capStrobes_t   strobes,
  output logic [2*DW-1:0] wideData
);

  localparam int WW = 2 * DW;

  logic [DW-1:0] riseHalf;
  logic [DW-1:0] fallHalf;
  logic [WW-1:0] joined;

  // rising-edge capture path
  always_ff @(posedge capClk or posedge rst) begin
    if (rst) riseHalf <= '0;
    else     riseHalf <= ddrData;
  end

  // falling-edge capture path
  always_ff @(negedge capClk or posedge rst) begin
    if (rst) fallHalf <= '0;
    else     fallHalf <= ddrData;
  end

  // lane placement: rising sample low, falling sample high
  for (genvar g = 0; g < DW; g++) begin : g_lane
    assign joined[g]      = riseHalf[g];
    assign joined[g + DW] = fallHalf[g];
  end

  // realignment register on the following rising edge
  always_ff @(posedge capClk or posedge rst) begin
    if (rst)                   wideData <= '0;
    else if (strobes.loadWide) wideData <= joined;
  end

  // R1: low lane carries the rising sample
  p_low_lane_r1: assert property (@(posedge capClk) disable iff (rst)
    strobes.loadWide |=> (wideData[DW-1:0] == $past(riseHalf)));

  // R2: high lane carries the falling sample
  p_high_lane_r2: assert property (@(posedge capClk) disable iff (rst)
    strobes.loadWide |=> (wideData[WW-1:DW] == $past(fallHalf)));

  // R5: an incomplete beat leaves the word untouched
  p_hold_idle_r5: assert property (@(posedge capClk) disable iff (rst)
    !strobes.loadWide |=> $stable(wideData));

  // R6: reset holds the word cleared
  always @(negedge capClk) begin
    if (rst) p_reset_word_r6: assert (wideData == '0);
  end

endmodule

// File: rtl/ddr_capture_widen.sv
module ddr_capture_widen
  import ddr_cap_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            capClk,
  input  logic            rst,
  input  logic [DW-1:0]   ddrData,
  input  logic            ddrValid,
  output logic [2*DW-1:0] wideData,
  output logic            wideValid
);

  capStrobes_t strobes;

  ddr_cap_ctrl u_ctrl (
    .capClk    (capClk),
    .rst       (rst),
    .ddrValid  (ddrValid),
    .strobes   (strobes),
    .wideValid (wideValid)
  );

  ddr_cap_dpath #(.DW(DW)) u_dpath (
    .capClk   (capClk),
    .rst      (rst),
    .ddrData  (ddrData),
    .strobes  (strobes),
    .wideData (wideData)
  );

endmodule

// File: tb/ddr_capture_widen_bench.sv
module ddr_capture_widen_bench;

  localparam int DW = 16;

  logic            capClk = 1'b0;
  logic            rst = 1'b1;
  logic [DW-1:0]   ddrData = '0;
  logic            ddrValid = 1'b0;
  logic [2*DW-1:0] wideData;
  logic            wideValid;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic [DW-1:0]   pLo = '0;
  logic [DW-1:0]   pHi = '0;
  bit              pV = 0;
  logic [2*DW-1:0] expData = '0;
  bit              expValid = 0;

  ddr_capture_widen #(.DW(DW)) u_ddr_capture_widen (
    .capClk(capClk), .rst(rst), .ddrData(ddrData), .ddrValid(ddrValid),
    .wideData(wideData), .wideValid(wideValid)
  );

  always #2 capClk = ~capClk;   // 4 ns period

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*DW-1:0] joinModel(logic [DW-1:0] lo, logic [DW-1:0] hi);
    return {hi, lo};
  endfunction

  // one beat: low half before the rising edge, high half before the falling edge
  task automatic beat(logic [DW-1:0] lo, logic [DW-1:0] hi, bit vlo, bit vhi);
    @(negedge capClk); #1;
    // R3: nothing moves between edges
    chk(wideData == expData, "R3 data stable mid-cycle", 64'(wideData), 64'(expData));
    chk(wideValid == expValid, "R3 flag stable mid-cycle", 64'(wideValid), 64'(expValid));
    ddrData = lo; ddrValid = vlo;
    @(posedge capClk); #1;
    ddrData = hi; ddrValid = vhi;
    // outputs now reflect the previous beat
    if (pV) expData = joinModel(pLo, pHi);
    expValid = pV;
    chk(wideValid == expValid, "R4 valid flag", 64'(wideValid), 64'(expValid));
    if (expValid) begin
      chk(wideData[DW-1:0] == expData[DW-1:0], "R1 low lane", 64'(wideData[DW-1:0]), 64'(expData[DW-1:0]));
      chk(wideData[2*DW-1:DW] == expData[2*DW-1:DW], "R2 high lane", 64'(wideData[2*DW-1:DW]), 64'(expData[2*DW-1:DW]));
    end else begin
      chk(wideData == expData, "R5 hold on invalid beat", 64'(wideData), 64'(expData));
    end
    pLo = lo; pHi = hi; pV = vlo && vhi;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge capClk);
    #1;
    chk(wideData == '0, "R6 reset word", 64'(wideData), 64'd0);
    chk(wideValid == 1'b0, "R6 reset flag", 64'(wideValid), 64'd0);
    rst = 1'b0;

    // directed: lane order and partial qualifiers
    beat(16'hFFFF, 16'h0000, 1, 1);
    beat(16'h0000, 16'hFFFF, 1, 1);
    beat(16'h1234, 16'hABCD, 1, 0);   // R4 rising-only
    beat(16'h5555, 16'hAAAA, 0, 1);   // R4 falling-only
    beat(16'h0F0F, 16'hF0F0, 0, 0);
    // R7: back-to-back valid beats
    for (int i = 0; i < 8; i++) beat(16'(i * 3 + 1), 16'(16'h8000 | i), 1, 1);

    // random traffic
    for (int i = 0; i < 300; i++) begin
      beat(16'($urandom), 16'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0);
    end

    // R6: reset raised between edges
    beat(16'hC3C3, 16'h3C3C, 1, 1);
    @(negedge capClk); #1;
    rst = 1'b1;
    #0.5;
    chk(wideData == '0, "R6 async clear word", 64'(wideData), 64'd0);
    chk(wideValid == 1'b0, "R6 async clear flag", 64'(wideValid), 64'd0);
    @(posedge capClk); #1;
    chk(wideValid == 1'b0, "R6 flag held in reset", 64'(wideValid), 64'd0);
    @(negedge capClk); #1;
    rst = 1'b0;
    ddrValid = 1'b0;
    pV = 0; expData = '0; expValid = 0;
    beat(16'h2468, 16'h1357, 1, 1);
    beat(16'h0000, 16'h0000, 0, 0);
    beat(16'h0000, 16'h0000, 0, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule